// File: doc/BRIEF.md
# Two-Level Interrupt Priority Controller

This block sits inside a processor core and decides which of 32 level-sensitive request lines is handed to the processor, and at which of two priority tiers. Software programs a per-line enable mask, a per-line tier mask and a small status word through a simple register port. The status word carries one enable bit and one active flag per tier. When a request is eligible, the block raises a one-cycle take strobe together with the line number and the tier, and it marks that tier active. A return pulse from the processor ends the handler at the highest tier that is currently active.

Only two handler contexts exist, one per tier. A high-tier request may interrupt a running low-tier handler. A low-tier request is held off whenever any handler is running, because a second low-tier entry would overwrite the single saved low-tier context. Lines 0 to 2 are reserved and never produce a take. Line 3 carries the timer request; it behaves like any other line.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the enable mask, the tier mask, both tier enables and both active flags are zero, and take is low.
- R2: Register port: cfg_addr 0 selects the enable mask, 1 the tier mask (bit set = high tier), 2 the status word with bit 0 = low-tier enable, bit 1 = high-tier enable, bit 2 = low-tier active, bit 3 = high-tier active. Writes to address 2 change only bits 0 and 1; address 3 reads zero and ignores writes. cfg_rdata shows the selected register combinationally, and a write is visible after the clock edge that samples it.
- R3: A line whose enable bit is clear is never taken.
- R4: Lines 0, 1 and 2 are never taken, whatever their enable and tier bits.
- R5: Requests are level-sensitive: a request counts only in a cycle in which its input is high at the clock edge; a pulse that arrives while the line cannot be taken leaves no trace.
- R6: Among takeable requests, a high-tier one beats any low-tier one; within a tier the lowest-numbered line wins.
- R7: A high-tier request is taken only when the high-tier enable is set and the high-tier active flag is clear; it may be taken while the low-tier flag is set.
- R8: A low-tier request is taken only when the low-tier enable is set and both active flags are clear.
- R9: The cycle after the clock edge at which a request is chosen, take is high for that one cycle, take_line holds the chosen line, take_hi holds its tier (1 = high), and the matching active flag reads set; take_line and take_hi keep their last values otherwise.
- R10: A return pulse clears the high-tier flag if it is set, otherwise the low-tier flag. A return and a take at the same edge both take effect.
- R11: A write to the enable or tier mask affects the choice from the following edge on, not at the edge that performs the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req | input | 32 | Level-sensitive request lines |
| ret_pulse | input | 1 | Handler return, one cycle |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |
| take | output | 1 | One-cycle strobe for an accepted request |
| take_line | output | 5 | Line number of the last accepted request |
| take_hi | output | 1 | Tier of the last accepted request, 1 = high |

## Verification
The interesting collision is a return pulse arriving at the same edge as a new take: with only the low-tier flag set, a high-tier request and a return in one cycle must clear the low-tier flag and set the high-tier flag together. The bench provokes it directly and again through a long stretch of pseudo-random requests, returns and status writes. A behavioural model in the bench predicts take, line, tier and the read word for every cycle, and any divergence on the status word after such an edge shows which of the two updates was lost.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_TIER   = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_NONE   = 2'd3
  } cfg_sel_e;

  localparam int ST_E_LO = 0;
  localparam int ST_E_HI = 1;
  localparam int ST_A_LO = 2;
  localparam int ST_A_HI = 3;
  localparam int ST_BITS = 4;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_prio_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [1:0]           addr,
  input  logic [NUM_LINES-1:0] wdata,
  output logic [NUM_LINES-1:0] en_mask,
  output logic [NUM_LINES-1:0] tier_mask,
  output logic                 en_lo,
  output logic                 en_hi
);

  logic [NUM_LINES-1:0] en_mask_d, tier_mask_d;
  logic                 en_lo_d, en_hi_d;
  logic                 wr_en, wr_tier, wr_stat;

  always_comb begin
    wr_en   = we && (cfg_sel_e'(addr) == SEL_ENABLE);
    wr_tier = we && (cfg_sel_e'(addr) == SEL_TIER);
    wr_stat = we && (cfg_sel_e'(addr) == SEL_STATUS);
    en_mask_d   = wr_en   ? wdata : en_mask;
    tier_mask_d = wr_tier ? wdata : tier_mask;
    en_lo_d     = wr_stat ? wdata[ST_E_LO] : en_lo;
    en_hi_d     = wr_stat ? wdata[ST_E_HI] : en_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_mask   <= '0;
      tier_mask <= '0;
      en_lo     <= 1'b0;
      en_hi     <= 1'b0;
    end else begin
      en_mask   <= en_mask_d;
      tier_mask <= tier_mask_d;
      en_lo     <= en_lo_d;
      en_hi     <= en_hi_d;
    end
  end

  assert_status_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 2'd2) |=> (en_lo == $past(wdata[0]) && en_hi == $past(wdata[1])));

  assert_enable_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr == 2'd0) |=> $stable(en_mask));

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NUM_LINES = 32,
  localparam int LW = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] cand,
  output logic                 hit,
  output logic [LW-1:0]        idx
);

  always_comb begin
    hit = |cand;
    idx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (cand[i]) idx = LW'(i);
    end
  end

endmodule

// File: rtl/irq_level_track.sv
module irq_level_track #(
  parameter int NUM_LINES = 32,
  localparam int LW = $clog2(NUM_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          grant,
  input  logic          grant_hi,
  input  logic [LW-1:0] grant_idx,
  input  logic          ret,
  output logic          act_lo,
  output logic          act_hi,
  output logic          take,
  output logic [LW-1:0] take_line,
  output logic          take_hi
);

  logic          act_lo_d, act_hi_d, take_d, take_hi_d;
  logic [LW-1:0] take_line_d;

  always_comb begin
    act_hi_d = act_hi;
    act_lo_d = act_lo;
    if (ret) begin
      if (act_hi) act_hi_d = 1'b0;
      else        act_lo_d = 1'b0;
    end
    if (grant && grant_hi)  act_hi_d = 1'b1;
    if (grant && !grant_hi) act_lo_d = 1'b1;
    take_d      = grant;
    take_line_d = grant ? grant_idx : take_line;
    take_hi_d   = grant ? grant_hi  : take_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_lo    <= 1'b0;
      act_hi    <= 1'b0;
      take      <= 1'b0;
      take_line <= '0;
      take_hi   <= 1'b0;
    end else begin
      act_lo    <= act_lo_d;
      act_hi    <= act_hi_d;
      take      <= take_d;
      take_line <= take_line_d;
      take_hi   <= take_hi_d;
    end
  end

  assert_hi_take_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_hi) |-> act_hi);

  assert_lo_take_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !take_hi) |-> (act_lo && !act_hi));

  assert_ret_clears_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && act_hi) |=> !act_hi);

  assert_no_hi_reentry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_hi) |=> !(take && take_hi));

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int NUM_RSVD  = 3,
  localparam int LW = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_req,
  input  logic                 ret_pulse,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_addr,
  input  logic [NUM_LINES-1:0] cfg_wdata,
  output logic [NUM_LINES-1:0] cfg_rdata,
  output logic                 take,
  output logic [LW-1:0]        take_line,
  output logic                 take_hi
);

  localparam logic [NUM_LINES-1:0] USABLE = {NUM_LINES{1'b1}} << NUM_RSVD;

  logic                 rst_meta, rst_n_i;
  logic [NUM_LINES-1:0] en_mask, tier_mask, live;
  logic                 en_lo, en_hi, act_lo, act_hi;
  logic [NUM_LINES-1:0] cand [2];
  logic                 hit  [2];
  logic [LW-1:0]        idx  [2];
  logic                 ok_hi, ok_lo, grant, grant_hi;
  logic [LW-1:0]        grant_idx;
  logic [ST_BITS-1:0]   status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_i  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_i  <= rst_meta;
    end
  end

  irq_cfg_regs #(.NUM_LINES(NUM_LINES)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .we        (cfg_we),
    .addr      (cfg_addr),
    .wdata     (cfg_wdata),
    .en_mask   (en_mask),
    .tier_mask (tier_mask),
    .en_lo     (en_lo),
    .en_hi     (en_hi)
  );

  always_comb begin
    live    = irq_req & en_mask & USABLE;
    cand[0] = live & ~tier_mask;
    cand[1] = live & tier_mask;
  end

  for (genvar t = 0; t < 2; t++) begin : g_tier
    irq_pick #(.NUM_LINES(NUM_LINES)) u_pick (
      .cand (cand[t]),
      .hit  (hit[t]),
      .idx  (idx[t])
    );
  end

  always_comb begin
    ok_hi     = en_hi && !act_hi;
    ok_lo     = en_lo && !act_lo && !act_hi;
    grant_hi  = hit[1] && ok_hi;
    grant     = grant_hi || (hit[0] && ok_lo);
    grant_idx = grant_hi ? idx[1] : idx[0];
  end

  irq_level_track #(.NUM_LINES(NUM_LINES)) u_track (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .grant     (grant),
    .grant_hi  (grant_hi),
    .grant_idx (grant_idx),
    .ret       (ret_pulse),
    .act_lo    (act_lo),
    .act_hi    (act_hi),
    .take      (take),
    .take_line (take_line),
    .take_hi   (take_hi)
  );

  always_comb begin
    status          = '0;
    status[ST_E_LO] = en_lo;
    status[ST_E_HI] = en_hi;
    status[ST_A_LO] = act_lo;
    status[ST_A_HI] = act_hi;
    case (cfg_sel_e'(cfg_addr))
      SEL_ENABLE: cfg_rdata = en_mask;
      SEL_TIER:   cfg_rdata = tier_mask;
      SEL_STATUS: cfg_rdata = NUM_LINES'(status);
      default:    cfg_rdata = '0;
    endcase
  end

  assert_reserved_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n_i)
    take |-> (take_line >= LW'(NUM_RSVD)));

  assert_lo_entry_idle_R8: assert property (@(posedge clk) disable iff (!rst_n_i)
    (take && !take_hi) |-> ($past(!act_lo) && $past(!act_hi)));

  assert_hi_entry_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n_i)
    (take && take_hi) |-> ($past(en_hi) && $past(!act_hi)));

endmodule

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_req = '0;
  logic        ret_pulse = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        take;
  logic [4:0]  take_line;
  logic        take_hi;

  always #2 clk = ~clk;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .ret_pulse (ret_pulse),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .take      (take),
    .take_line (take_line),
    .take_hi   (take_hi)
  );

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";

  // reference model state
  bit [31:0] m_en, m_tier;
  bit        m_elo, m_ehi, m_alo, m_ahi, m_take, m_hi;
  int        m_line;

  task automatic check(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit [31:0] exp_read();
    case (cfg_addr)
      2'd0: return m_en;
      2'd1: return m_tier;
      2'd2: return {28'd0, m_ahi, m_alo, m_ehi, m_elo};
      default: return 32'd0;
    endcase
  endfunction

  task automatic cycle();
    int g_hi = -1, g_lo = -1;
    bit t_hi = 0, t_lo = 0;
    bit n_alo = m_alo, n_ahi = m_ahi;
    if (rst_n) begin
      for (int i = 3; i < 32; i++) begin
        if (irq_req[i] && m_en[i]) begin
          if (m_tier[i] && g_hi < 0) g_hi = i;
          if (!m_tier[i] && g_lo < 0) g_lo = i;
        end
      end
      if (g_hi >= 0 && m_ehi && !m_ahi) t_hi = 1;
      else if (g_lo >= 0 && m_elo && !m_alo && !m_ahi) t_lo = 1;
      if (ret_pulse) begin
        if (m_ahi) n_ahi = 0;
        else       n_alo = 0;
      end
      if (t_hi) n_ahi = 1;
      if (t_lo) n_alo = 1;
    end
    @(posedge clk);
    #1;
    if (!rst_n) begin
      m_en = 0; m_tier = 0; m_elo = 0; m_ehi = 0; m_alo = 0; m_ahi = 0;
      m_take = 0; m_hi = 0; m_line = 0;
    end else begin
      m_take = t_hi || t_lo;
      if (t_hi) begin m_line = g_hi; m_hi = 1; end
      if (t_lo) begin m_line = g_lo; m_hi = 0; end
      m_alo = n_alo;
      m_ahi = n_ahi;
      if (cfg_we) begin
        case (cfg_addr)
          2'd0: m_en = cfg_wdata;
          2'd1: m_tier = cfg_wdata;
          2'd2: begin m_elo = cfg_wdata[0]; m_ehi = cfg_wdata[1]; end
          default: ;
        endcase
      end
    end
    check("take", take, m_take);
    check("take_line", take_line, m_line);
    check("take_hi", take_hi, m_hi);
    check("rdata", cfg_rdata, exp_read());
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) cycle();
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    cycle();
    cfg_we = 0; cfg_addr = 2'd2;
  endtask

  task automatic ret();
    ret_pulse = 1;
    cycle();
    ret_pulse = 0;
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit [31:0] lcg = 32'h1234_5678;
    // R1: reset state
    tag = "R1";
    run(3);
    #1 rst_n = 1;
    run(4);
    cfg_addr = 2'd0; cycle();
    cfg_addr = 2'd1; cycle();
    cfg_addr = 2'd2; cycle();

    // R2: register access, read-only flags, unused address
    tag = "R2";
    wr(2'd0, 32'hA5A5_0F0F); cfg_addr = 2'd0; cycle();
    wr(2'd1, 32'h0000_FFFF); cfg_addr = 2'd1; cycle();
    wr(2'd2, 32'hFFFF_FFFF); cycle();
    wr(2'd3, 32'h1234_5678); cfg_addr = 2'd3; cycle();
    cfg_addr = 2'd0; cycle();
    cfg_addr = 2'd2;
    wr(2'd1, 32'h0);
    wr(2'd0, 32'hFFFF_FFFF);

    // R4: reserved lines never taken
    tag = "R4";
    irq_req = 32'h7; run(4);
    wr(2'd1, 32'h7); run(3);
    wr(2'd1, 32'h0);
    irq_req = 32'h27; run(3);
    irq_req = 0; ret(); run(2);

    // R3: disabled lines
    tag = "R3";
    wr(2'd0, 32'hFFFF_FEFF);
    irq_req = 32'h100; run(4);
    irq_req = 32'h300; run(3);
    irq_req = 0; ret(); run(2);

    // R6: tier priority and lowest index
    tag = "R6";
    wr(2'd1, 32'h0010_0000);
    irq_req = 32'h0010_0400; run(3);
    irq_req = 0; ret(); run(2);
    irq_req = 32'h0000_5000; run(3);
    irq_req = 0; ret(); run(2);

    // R8: low tier blocked while active or disabled
    tag = "R8";
    irq_req = 32'h0000_1000; run(2);
    irq_req = 32'h0000_0810; run(3);
    irq_req = 0; ret();
    wr(2'd2, 32'h2);
    irq_req = 32'h0000_0810; run(3);
    irq_req = 0;
    wr(2'd2, 32'h3);

    // R7 and R10: preemption, blocked re-entry, return order, collision
    tag = "R7";
    irq_req = 32'h0000_0020; run(2);
    irq_req = 32'h0010_0000; run(2);
    irq_req = 32'h0030_0000; run(3);
    irq_req = 0;
    tag = "R10";
    ret(); run(1);
    ret(); run(1);
    irq_req = 32'h0000_0020; run(2);
    irq_req = 32'h0010_0000; ret_pulse = 1; cycle(); ret_pulse = 0;
    irq_req = 0; run(2);
    ret(); run(2);
    tag = "R7";
    wr(2'd2, 32'h1);
    irq_req = 32'h0010_0000; run(3);
    irq_req = 0;
    wr(2'd2, 32'h3);

    // R5: short pulse while blocked leaves nothing
    tag = "R5";
    irq_req = 32'h0000_0040; run(2);
    irq_req = 32'h0000_0080; cycle();
    irq_req = 0; run(2);
    ret(); run(3);

    // R11: mask write and request at the same edge
    tag = "R11";
    wr(2'd0, 32'h0);
    irq_req = 32'h0000_0200;
    wr(2'd0, 32'h0000_0200);
    run(2);
    irq_req = 0; ret();
    irq_req = 32'h0000_0200;
    wr(2'd1, 32'h0000_0200);
    run(2);
    irq_req = 0; ret(); run(2);

    // R9 and R6: pseudo-random mix against the model
    tag = "R9";
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd1, 32'hF0F0_00F8);
    for (int k = 0; k < 3000; k++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      irq_req   = lcg & {lcg[7:0], lcg[31:8]};
      ret_pulse = (lcg[3:0] < 4'd3);
      cfg_we    = (lcg[9:4] == 6'd0);
      cfg_addr  = cfg_we ? 2'(lcg[11:10] % 3) : 2'(lcg[13:12]);
      cfg_wdata = {lcg[15:0], lcg[31:16]} | 32'h3;
      cycle();
    end
    cfg_we = 0; ret_pulse = 0; irq_req = 0;
    run(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule